// File: doc/BRIEF.md
# Display RAM Address Counter with Line-Aware Wrap

This block holds the 7-bit address counter used to reach an 80-byte character display RAM, together with the horizontal shift offset of the visible window. It supports two screen layouts. In the one-line layout, a single 80-byte line shows 24 positions. In the two-line layout, two 40-byte lines each show 12 positions. A gap separates the two lines in the address map: line 1 uses 0x00..0x27 and line 2 uses 0x40..0x67.

Command decode drives the block through several strobes. Set-address strobes load the counter, either as a display address or as a character-pattern address. A data-access strobe steps the counter by one in the entry-mode direction. A shift strobe moves the visible window left or right. A home strobe clears the counter and the offset.

The block applies wrap-around in two ways. Read/write stepping carries over from the end of one line into the next line. Window shifting wraps inside each line. For every visible position that the display scan asks for, the block returns the RAM address to fetch. It also reports whether a cursor may be drawn.

Top module: `ddram_addr_ctl`

## Requirements
- R1: After reset, `addr` is 0x00, `in_cg` is 0, `cursor_on` is 1, and the shift offset is zero, so `fetch_addr` for position 0 of line 0 is 0x00.
- R2: When `ld_dd` is high, `addr` takes `ld_val` and `in_cg` goes to 0 at the next edge. When `ld_cg` is high and `ld_dd` is low, `addr` takes `{1'b0, ld_val[5:0]}` and `in_cg` goes to 1. If both are high in the same cycle, `ld_dd` wins.
- R3: In the one-line layout (`two_line`=0), with `in_cg`=0, a `step` changes `addr` by +1 when `dir_up`=1 and by -1 otherwise. Stepping up wraps 0x4F to 0x00, and stepping down wraps 0x00 to 0x4F.
- R4: In the two-line layout (`two_line`=1), with `in_cg`=0, stepping up moves 0x27 to 0x40 and 0x67 to 0x00. Stepping down moves 0x40 to 0x27 and 0x00 to 0x67. All other addresses change by one.
- R5: With `in_cg`=1, a `step` moves `addr` by one modulo 64, so bit 6 stays 0. For example, 0x3F steps up to 0x00 and 0x00 steps down to 0x3F.
- R6: `cursor_on` is 0 exactly while `in_cg` is 1.
- R7: With zero shift, `fetch_addr` equals `pos_col` in the one-line layout. In the two-line layout it is `pos_col` for line 0 (`pos_line`=0) and 0x40 + `pos_col` for line 1. `fetch_addr` is combinational from the position inputs and the current offset.
- R8: Each `shift_en` cycle moves the offset by one within the line length L (80 for one line, 40 for two lines). `shift_right`=1 decrements the offset and `shift_right`=0 increments it. `fetch_addr` = base + ((`pos_col` + offset) mod L). So one right shift shows 0x4F (or 0x27 / 0x67) at position 0, and one left shift shows 0x01 (or 0x41).
- R9: `home` clears `addr`, `in_cg` and the offset at the next edge. It takes priority over loads, steps and shifts issued in the same cycle.
- R10: In a cycle with no `home`, load or `step`, `addr` and `in_cg` hold their values.
- R11: A load in the same cycle as `step` takes effect and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| two_line | input | 1 | Layout select: 0 = one 80-byte line, 1 = two 40-byte lines |
| dir_up | input | 1 | Step direction: 1 = increment, 0 = decrement |
| home | input | 1 | Clear counter and shift offset |
| ld_dd | input | 1 | Load a display RAM address |
| ld_cg | input | 1 | Load a character-pattern RAM address |
| ld_val | input | 7 | Address value for the loads |
| step | input | 1 | One data access has completed |
| shift_en | input | 1 | Shift the visible window by one |
| shift_right | input | 1 | Shift direction: 1 = right, 0 = left |
| pos_line | input | 1 | Line of the visible position being fetched |
| pos_col | input | 5 | Column of the visible position, counted from 0 |
| addr | output | 7 | Address counter |
| in_cg | output | 1 | The counter holds a character-pattern address |
| cursor_on | output | 1 | A cursor may be drawn at `addr` |
| fetch_addr | output | 7 | RAM address for the requested visible position |

## Verification
A command strobe applied before a rising edge shows up on `addr`, `in_cg` and `cursor_on` one cycle later, after exactly one register stage. `fetch_addr` has no register between the position inputs and the output. It reflects a shift one cycle after the shift strobe and reflects a change of position within the same cycle. The bench changes inputs only on falling edges. It checks registered results at the falling edge that follows the capturing rising edge, and it checks `fetch_addr` one nanosecond after the position inputs change. Every valid address is stepped in both directions in both layouts, and every offset of each line length is swept against every visible position.

// File: rtl/ddram_addr_ctl.sv
module ddram_addr_ctl #(
  parameter int AW     = 7,
  parameter int CGW    = 6,
  parameter int LEN1   = 80,
  parameter int LEN2   = 40,
  parameter int L2BASE = 64,
  parameter int PW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_line,
  input  logic          dir_up,
  input  logic          home,
  input  logic          ld_dd,
  input  logic          ld_cg,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          shift_en,
  input  logic          shift_right,
  input  logic          pos_line,
  input  logic [PW-1:0] pos_col,
  output logic [AW-1:0] addr,
  output logic          in_cg,
  output logic          cursor_on,
  output logic [AW-1:0] fetch_addr
);
  localparam int OW = $clog2(LEN1);
  localparam int SW = OW + 1;
  localparam logic [AW-1:0] ONE_END = AW'(LEN1 - 1);
  localparam logic [AW-1:0] L1_END  = AW'(LEN2 - 1);
  localparam logic [AW-1:0] L2_BEG  = AW'(L2BASE);
  localparam logic [AW-1:0] L2_END  = AW'(L2BASE + LEN2 - 1);

  logic [AW-1:0]  ac_q, ac_step;
  logic           cg_q;
  logic [OW-1:0]  off_q, off_eff, off_nxt, llen;
  logic [CGW-1:0] cg_lo;
  logic [SW-1:0]  sum, wrapped;
  logic [AW-1:0]  base;

  assign llen    = two_line ? OW'(LEN2) : OW'(LEN1);
  assign off_eff = (off_q >= llen) ? off_q - llen : off_q;
  assign cg_lo   = dir_up ? ac_q[CGW-1:0] + CGW'(1) : ac_q[CGW-1:0] - CGW'(1);

  always_comb begin
    if (cg_q)
      ac_step = AW'(cg_lo);
    else if (!two_line) begin
      if (dir_up) ac_step = (ac_q == ONE_END) ? '0 : ac_q + AW'(1);
      else        ac_step = (ac_q == '0) ? ONE_END : ac_q - AW'(1);
    end else begin
      if (dir_up)
        ac_step = (ac_q == L1_END) ? L2_BEG :
                  (ac_q == L2_END) ? '0 : ac_q + AW'(1);
      else
        ac_step = (ac_q == L2_BEG) ? L1_END :
                  (ac_q == '0) ? L2_END : ac_q - AW'(1);
    end
  end

  always_comb begin
    if (shift_right) off_nxt = (off_eff == '0) ? llen - OW'(1) : off_eff - OW'(1);
    else             off_nxt = (off_eff == llen - OW'(1)) ? '0 : off_eff + OW'(1);
  end

  assign sum        = {1'b0, off_eff} + SW'(pos_col);
  assign wrapped    = (sum >= {1'b0, llen}) ? sum - {1'b0, llen} : sum;
  assign base       = (two_line && pos_line) ? L2_BEG : '0;
  assign fetch_addr = base + AW'(wrapped[OW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q  <= '0;
      cg_q  <= 1'b0;
      off_q <= '0;
    end else if (home) begin
      ac_q  <= '0;
      cg_q  <= 1'b0;
      off_q <= '0;
    end else begin
      if (ld_dd) begin
        ac_q <= ld_val;
        cg_q <= 1'b0;
      end else if (ld_cg) begin
        ac_q <= AW'(ld_val[CGW-1:0]);
        cg_q <= 1'b1;
      end else if (step) begin
        ac_q <= ac_step;
      end
      if (shift_en) off_q <= off_nxt;
    end
  end

  assign addr      = ac_q;
  assign in_cg     = cg_q;
  assign cursor_on = !cg_q;
endmodule

// File: rtl/ddram_addr_ctl_chk.sv
module ddram_addr_ctl_chk #(
  parameter int AW     = 7,
  parameter int CGW    = 6,
  parameter int LEN1   = 80,
  parameter int LEN2   = 40,
  parameter int L2BASE = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          two_line,
  input logic          dir_up,
  input logic          home,
  input logic          ld_dd,
  input logic          ld_cg,
  input logic [AW-1:0] ld_val,
  input logic          step,
  input logic [AW-1:0] addr,
  input logic          in_cg,
  input logic          cursor_on
);
  localparam logic [AW-1:0] ONE_END = AW'(LEN1 - 1);
  localparam logic [AW-1:0] L1_END  = AW'(LEN2 - 1);
  localparam logic [AW-1:0] L2_BEG  = AW'(L2BASE);

  logic quiet;
  assign quiet = !home && !ld_dd && !ld_cg;

  // R9
  home_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    home |=> (addr == '0) && !in_cg);

  // R2
  ld_cg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!home && !ld_dd && ld_cg) |=> in_cg && !cursor_on &&
      (addr == AW'($past(ld_val[CGW-1:0]))));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !step) |=> $stable(addr) && $stable(in_cg));

  // R4
  two_line_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step && !in_cg && two_line && dir_up && addr == L1_END) |=> addr == L2_BEG);

  // R3
  one_line_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step && !in_cg && !two_line && dir_up && addr < ONE_END) |=>
      addr == $past(addr) + AW'(1));

  // R5
  cg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_cg |-> addr[AW-1] == 1'b0);
endmodule

bind ddram_addr_ctl ddram_addr_ctl_chk #(
  .AW(AW), .CGW(CGW), .LEN1(LEN1), .LEN2(LEN2), .L2BASE(L2BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .two_line(two_line), .dir_up(dir_up),
  .home(home), .ld_dd(ld_dd), .ld_cg(ld_cg), .ld_val(ld_val), .step(step),
  .addr(addr), .in_cg(in_cg), .cursor_on(cursor_on)
);

// File: tb/ddram_addr_ctl_tb_top.sv
`timescale 1ns/1ps
module ddram_addr_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_line = 1'b0, dir_up = 1'b1, home = 1'b0, ld_dd = 1'b0, ld_cg = 1'b0;
  logic [6:0] ld_val = '0;
  logic step = 1'b0, shift_en = 1'b0, shift_right = 1'b0, pos_line = 1'b0;
  logic [4:0] pos_col = '0;
  logic [6:0] addr, fetch_addr;
  logic in_cg, cursor_on;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddram_addr_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .two_line(two_line), .dir_up(dir_up), .home(home),
    .ld_dd(ld_dd), .ld_cg(ld_cg), .ld_val(ld_val), .step(step),
    .shift_en(shift_en), .shift_right(shift_right), .pos_line(pos_line),
    .pos_col(pos_col), .addr(addr), .in_cg(in_cg), .cursor_on(cursor_on),
    .fetch_addr(fetch_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_step(int a, bit up, bit two);
    int lin, n;
    if (!two) return up ? (a + 1) % 80 : (a + 79) % 80;
    lin = (a >= 64) ? a - 64 + 40 : a;
    n = up ? (lin + 1) % 80 : (lin + 79) % 80;
    return (n < 40) ? n : n - 40 + 64;
  endfunction

  task automatic load_dd(input int a);
    ld_dd = 1'b1; ld_val = 7'(a);
    tick();
    ld_dd = 1'b0;
  endtask

  task automatic do_home();
    home = 1'b1;
    tick();
    home = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int off, len;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    #1;
    // R1
    check("R1 addr", addr, 0);
    check("R1 in_cg", in_cg, 0);
    check("R1 cursor_on", cursor_on, 1);
    check("R1 fetch", fetch_addr, 0);
    @(negedge clk);

    // R3 / R4 sweep: every valid address, both directions, both layouts
    for (int two = 0; two < 2; two++) begin
      two_line = two[0];
      for (int up = 0; up < 2; up++) begin
        dir_up = up[0];
        for (int i = 0; i < 80; i++) begin
          int a;
          a = (two == 1 && i >= 40) ? i - 40 + 64 : i;
          load_dd(a);
          check("R2 load_dd", addr, a);
          step = 1'b1;
          tick();
          step = 1'b0;
          if (two == 0) check("R3 step", addr, exp_step(a, up[0], 1'b0));
          else          check("R4 step", addr, exp_step(a, up[0], 1'b1));
        end
      end
    end

    // R10 hold
    two_line = 1'b0; dir_up = 1'b1;
    load_dd(37);
    tick(); tick();
    check("R10 hold addr", addr, 37);
    check("R10 hold in_cg", in_cg, 0);

    // R11 load beats step
    ld_dd = 1'b1; ld_val = 7'h15; step = 1'b1;
    tick();
    ld_dd = 1'b0; step = 1'b0;
    check("R11 load over step", addr, 8'h15);

    // R2 ld_dd wins over ld_cg
    ld_dd = 1'b1; ld_cg = 1'b1; ld_val = 7'h22;
    tick();
    ld_dd = 1'b0; ld_cg = 1'b0;
    check("R2 dd priority addr", addr, 8'h22);
    check("R2 dd priority in_cg", in_cg, 0);

    // R2 / R5 / R6 pattern-RAM mode
    ld_cg = 1'b1; ld_val = 7'h7F;
    tick();
    ld_cg = 1'b0;
    check("R2 load_cg addr", addr, 8'h3F);
    check("R2 load_cg in_cg", in_cg, 1);
    check("R6 cursor off", cursor_on, 0);
    for (int two = 0; two < 2; two++) begin
      two_line = two[0];
      dir_up = 1'b1; step = 1'b1;
      tick();
      step = 1'b0;
      check("R5 cg wrap up", addr, 0);
      dir_up = 1'b0; step = 1'b1;
      tick();
      step = 1'b0;
      check("R5 cg wrap down", addr, 8'h3F);
    end
    check("R6 cursor still off", cursor_on, 0);
    load_dd(5);
    check("R6 cursor back on", cursor_on, 1);

    // R7 / R8 window sweep: one line shifted right, two lines shifted left
    for (int two = 0; two < 2; two++) begin
      two_line = two[0];
      do_home();
      len = two ? 40 : 80;
      off = 0;
      for (int k = 0; k <= len; k++) begin
        for (int ln = 0; ln <= two; ln++) begin
          for (int p = 0; p < (two ? 12 : 24); p++) begin
            pos_line = ln[0]; pos_col = 5'(p);
            #1;
            if (k == 0) check("R7 unshifted fetch", fetch_addr, ln * 64 + p);
            else        check("R8 shifted fetch", fetch_addr, ln * 64 + (p + off) % len);
          end
        end
        @(negedge clk);
        shift_en = 1'b1; shift_right = (two == 0);
        tick();
        shift_en = 1'b0;
        off = (two == 0) ? (off + len - 1) % len : (off + 1) % len;
      end
    end

    // R8 single-step corners
    two_line = 1'b1; do_home();
    pos_col = 0;
    shift_en = 1'b1; shift_right = 1'b1;
    tick();
    shift_en = 1'b0;
    pos_line = 1'b0; #1; check("R8 right line1", fetch_addr, 8'h27);
    pos_line = 1'b1; #1; check("R8 right line2", fetch_addr, 8'h67);
    @(negedge clk);
    do_home();
    shift_en = 1'b1; shift_right = 1'b0;
    tick();
    shift_en = 1'b0;
    pos_line = 1'b1; #1; check("R8 left line2", fetch_addr, 8'h41);
    @(negedge clk);

    // R9 home beats load, step and shift in the same cycle
    load_dd(8'h45);
    home = 1'b1; ld_dd = 1'b1; ld_val = 7'h12; step = 1'b1; shift_en = 1'b1;
    tick();
    home = 1'b0; ld_dd = 1'b0; step = 1'b0; shift_en = 1'b0;
    pos_line = 1'b0; pos_col = 0;
    #1;
    check("R9 home addr", addr, 0);
    check("R9 home in_cg", in_cg, 0);
    check("R9 home offset", fetch_addr, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule